// File: doc/BRIEF.md
# Page-Mode DRAM Access Sequencer

This block sits between a processor's memory port and a DRAM whose row and column addresses share one set of address pins. For each memory cycle it chooses either a full access (row strobe, then column strobe) or a column-only access inside the row that is already open. Both strobes are active low. The choice does not compare the new row with the stored row. It is made from the processor's sequential flag and from whether the previous word was the last word of its row. A sequential request whose predecessor was not at a row end stays in the open row and finishes in one cycle. Every other memory request reopens a row.

Requests use a one-cycle look-ahead. At each rising edge where the sequencer's wait output is low, the sequencer takes the request inputs (memory request, sequential flag, write and word address) as the description of the cycle that follows. While wait is high, the processor holds its request and the sequencer ignores the inputs. A cycle with the memory request low is an internal cycle, and the open row stays open through it. A sequential flag after an internal cycle refers to the same address again, so that access reuses the row without waiting.

Top module: `dram_page_seq`

## Requirements
- R1: After reset the row strobe, column strobe and write strobe are high (inactive), wait is low and the DRAM address pins are zero.
- R2: A full access presents the row part of the word address (the top ROW_W bits) with the row strobe low and the column strobe high. In the next cycle it presents the column part (the low COL_W bits of the word address, zero-extended) with both strobes low.
- R3: Wait is high in every cycle of a full access before its column cycle and low in the column cycle. A column-only access never raises wait.
- R4: A sequential request with a row open, whose previous word index was not all ones, is a column-only access. In the first cycle after acceptance the column strobe is low, the row strobe stays low and the column address is on the pins.
- R5: A sequential request whose previous word index was all ones (a row crossing) runs a precharge cycle first. In that cycle the row strobe is high, wait is high and the new row is on the pins. A row cycle and a column cycle follow.
- R6: A non-sequential request is always a full access with a precharge when a row is open, even when it targets the open row.
- R7: A cycle with the memory request low keeps the open row: row strobe low, column strobe high, wait low. A following sequential request to the same address is column-only.
- R8: A non-sequential request after an internal cycle does not reuse the open row. It runs precharge, row and column cycles.
- R9: The write strobe is low only in the column cycle of a write request and is high in precharge, row and idle cycles.
- R10: When no row is open (after reset), any memory request, sequential or not, is a full access with no precharge cycle.
- R11: Changes to any request input while wait is high do not affect the access in progress. Its row and column come from the request as it was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_addr | input | WORD_AW | Word address of the next access (byte offset dropped) |
| mreq | input | 1 | Next cycle is a memory access |
| seq | input | 1 | Next address is previous plus one word, or the same address after an internal cycle |
| wr | input | 1 | Next access is a write |
| dram_addr | output | DA_W | Multiplexed row/column address pins |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| wait_o | output | 1 | Stall request to the processor |

## Verification
The bench covers the first sequential request after reset, which has no open row to reuse and must not fake a page hit. A design that trusted the flag alone would strobe a column with no row latched. It steps across the last word of a row: a design that skipped the row-end check would stay in the old row and read the wrong data. It also issues a non-sequential request to the row that is already open, which must still be a full access. It checks an internal cycle followed by a same-address sequential request, where a design that closed the row would stall for no reason, and it checks that a non-sequential request after that internal cycle reopens the row. Finally it scrambles the request inputs during wait cycles: a design that resampled them would put a wrong column on the pins.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_ROW  = 2'd2,
    PH_COL  = 2'd3
  } phase_t;
endpackage

// File: rtl/dps_hit_detect.sv
// Decides whether the next request may stay in the open row, using only the
// sequential flag and a one-bit memory of the previous word position.
module dps_hit_detect #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             mreq,
  input  logic             seq,
  input  logic [COL_W-1:0] word_col,
  output logic             hit
);
  logic prev_at_end;
  logic prev_internal;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_at_end   <= 1'b0;
      prev_internal <= 1'b0;
    end else if (accept) begin
      if (mreq) begin
        prev_at_end   <= &word_col;
        prev_internal <= 1'b0;
      end else begin
        prev_internal <= 1'b1;
      end
    end
  end

  // after an internal cycle the sequential address repeats, so no crossing
  assign hit = seq && (prev_internal || !prev_at_end);
endmodule

// File: rtl/dps_addr_split.sv
// Splits the word address into row and column pin images.
module dps_addr_split #(
  parameter int WORD_AW = 18,
  parameter int COL_W   = 8,
  parameter int DA_W    = 10
) (
  input  logic [WORD_AW-1:0] word_addr,
  output logic [DA_W-1:0]    row_pins,
  output logic [DA_W-1:0]    col_pins
);
  localparam int ROW_W = WORD_AW - COL_W;

  always_comb begin
    row_pins = '0;
    col_pins = '0;
    row_pins[ROW_W-1:0] = word_addr[WORD_AW-1:COL_W];
    col_pins[COL_W-1:0] = word_addr[COL_W-1:0];
  end
endmodule

// File: rtl/dps_ctrl.sv
// Strobe sequencer with registered outputs.
module dps_ctrl
  import dram_seq_pkg::*;
#(
  parameter int DA_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mreq,
  input  logic            wr,
  input  logic            hit,
  input  logic [DA_W-1:0] row_pins,
  input  logic [DA_W-1:0] col_pins,
  output logic            accept,
  output logic [DA_W-1:0] dram_addr,
  output logic            ras_n,
  output logic            cas_n,
  output logic            we_n,
  output logic            wait_o
);
  phase_t          phase;
  logic [DA_W-1:0] pend_col;
  logic            pend_wr;
  logic            row_open;

  assign accept   = !wait_o;
  assign row_open = !ras_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      dram_addr <= '0;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      we_n      <= 1'b1;
      wait_o    <= 1'b0;
      pend_col  <= '0;
      pend_wr   <= 1'b0;
    end else begin
      case (phase)
        PH_PRE: begin
          phase  <= PH_ROW;
          ras_n  <= 1'b0;
          wait_o <= 1'b1;
        end
        PH_ROW: begin
          phase     <= PH_COL;
          cas_n     <= 1'b0;
          dram_addr <= pend_col;
          we_n      <= !pend_wr;
          wait_o    <= 1'b0;
        end
        default: begin
          if (!mreq) begin
            phase <= PH_IDLE;
            cas_n <= 1'b1;
            we_n  <= 1'b1;
          end else if (hit && row_open) begin
            phase     <= PH_COL;
            cas_n     <= 1'b0;
            dram_addr <= col_pins;
            we_n      <= !wr;
          end else begin
            pend_col  <= col_pins;
            pend_wr   <= wr;
            dram_addr <= row_pins;
            cas_n     <= 1'b1;
            we_n      <= 1'b1;
            wait_o    <= 1'b1;
            if (row_open) begin
              phase <= PH_PRE;
              ras_n <= 1'b1;
            end else begin
              phase <= PH_ROW;
              ras_n <= 1'b0;
            end
          end
        end
      endcase
    end
  end

  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> !ras_n);  // R2
  AST_ROW_THEN_COL: assert property (@(posedge clk) disable iff (rst)
    (wait_o && !ras_n) |=> (!cas_n && !ras_n && !wait_o));  // R3
  AST_PRECHARGE_STALLS: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |-> wait_o);  // R5
  AST_PRECHARGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (ras_n && wait_o) |=> (!ras_n && wait_o));  // R5
  AST_WRITE_IN_COL: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (!cas_n && !wait_o));  // R9
endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq #(
  parameter int WORD_AW   = 18,
  parameter int ROW_WORDS = 256,
  localparam int COL_W    = $clog2(ROW_WORDS),
  localparam int ROW_W    = WORD_AW - COL_W,
  localparam int DA_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WORD_AW-1:0] word_addr,
  input  logic               mreq,
  input  logic               seq,
  input  logic               wr,
  output logic [DA_W-1:0]    dram_addr,
  output logic               ras_n,
  output logic               cas_n,
  output logic               we_n,
  output logic               wait_o
);
  logic            accept;
  logic            hit;
  logic [DA_W-1:0] row_pins;
  logic [DA_W-1:0] col_pins;

  dps_hit_detect #(.COL_W(COL_W)) u_hit (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .mreq     (mreq),
    .seq      (seq),
    .word_col (word_addr[COL_W-1:0]),
    .hit      (hit)
  );

  dps_addr_split #(.WORD_AW(WORD_AW), .COL_W(COL_W), .DA_W(DA_W)) u_split (
    .word_addr (word_addr),
    .row_pins  (row_pins),
    .col_pins  (col_pins)
  );

  dps_ctrl #(.DA_W(DA_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .mreq      (mreq),
    .wr        (wr),
    .hit       (hit),
    .row_pins  (row_pins),
    .col_pins  (col_pins),
    .accept    (accept),
    .dram_addr (dram_addr),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .wait_o    (wait_o)
  );
endmodule

// File: tb/dram_page_seq_bench.sv
module dram_page_seq_bench;
  localparam int WAW  = 18;
  localparam int CW   = 8;
  localparam int RW   = WAW - CW;
  localparam int DW   = (RW > CW) ? RW : CW;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [WAW-1:0] word_addr = '0;
  logic           mreq = 1'b0, seq = 1'b0, wr = 1'b0;
  logic [DW-1:0]  dram_addr;
  logic           ras_n, cas_n, we_n, wait_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dram_page_seq #(.WORD_AW(WAW), .ROW_WORDS(256)) u_dram_page_seq (
    .clk(clk), .rst(rst), .word_addr(word_addr), .mreq(mreq), .seq(seq), .wr(wr),
    .dram_addr(dram_addr), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .wait_o(wait_o)
  );

  function automatic logic [WAW-1:0] mk(input int row, input int col);
    return {RW'(row), CW'(col)};
  endfunction

  // compare {ras,cas,we,wait,addr} against expectation
  task automatic chk(input string tag, input logic r, input logic c, input logic w,
                     input logic wt, input int da);
    logic [DW+3:0] act, exp;
    act = {ras_n, cas_n, we_n, wait_o, dram_addr};
    exp = {r, c, w, wt, DW'(da)};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s ras/cas/we/wait/addr actual=%b_%0d expected=%b_%0d",
               tag, act[DW+3:DW], act[DW-1:0], exp[DW+3:DW], exp[DW-1:0]);
    end
  endtask

  task automatic drive(input logic m, input logic s, input logic w, input logic [WAW-1:0] a);
    mreq = m; seq = s; wr = w; word_addr = a;
  endtask

  task automatic step;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic full_acc(input string tag, input logic pre, input logic w, input int row, input int col);
    if (pre) begin step; chk({tag, " pre"}, 1, 1, 1, 1, row); end
    step; chk({tag, " row"}, 0, 1, 1, 1, row);
    step; chk({tag, " col"}, 0, 0, !w, 0, col);
  endtask

  task automatic t_reset;
    chk("R1 reset", 1, 1, 1, 0, 0);
  endtask

  task automatic t_seq_closed;  // R10 / R2 / R3
    drive(1, 1, 0, mk(3, 4));
    full_acc("R10 R2 R3 closed-row", 0, 0, 3, 4);
  endtask

  task automatic t_stream;  // R4
    drive(1, 1, 0, mk(3, 5)); step; chk("R4 seq col5", 0, 0, 1, 0, 5);
    drive(1, 1, 0, mk(3, 6)); step; chk("R4 seq col6", 0, 0, 1, 0, 6);
  endtask

  task automatic t_cross;  // R5
    drive(1, 0, 0, mk(3, 255));
    full_acc("R6 to row end", 1, 0, 3, 255);
    drive(1, 1, 0, mk(4, 0));
    full_acc("R5 crossing", 1, 0, 4, 0);
  endtask

  task automatic t_same_row;  // R6
    drive(1, 0, 0, mk(4, 1));
    full_acc("R6 nonseq same row", 1, 0, 4, 1);
  endtask

  task automatic t_internal;  // R7
    drive(0, 0, 0, mk(4, 1)); step; chk("R7 idle keeps row", 0, 1, 1, 0, 1);
    drive(1, 1, 0, mk(4, 1)); step; chk("R7 reuse col1", 0, 0, 1, 0, 1);
  endtask

  task automatic t_idle_nonseq;  // R8
    drive(0, 0, 0, mk(4, 1)); step; chk("R8 idle", 0, 1, 1, 0, 1);
    drive(1, 0, 0, mk(4, 2));
    full_acc("R8 nonseq after idle", 1, 0, 4, 2);
  endtask

  task automatic t_write;  // R9
    drive(1, 1, 1, mk(4, 3)); step; chk("R9 seq write col", 0, 0, 0, 0, 3);
    drive(1, 0, 1, mk(7, 9));
    full_acc("R9 full write", 1, 1, 7, 9);
  endtask

  task automatic t_hold;  // R11
    drive(1, 0, 0, mk(9, 20));
    step; chk("R11 pre", 1, 1, 1, 1, 9);
    drive(0, 1, 1, mk(1, 1));
    step; chk("R11 row", 0, 1, 1, 1, 9);
    drive(1, 1, 1, mk(2, 2));
    step; chk("R11 col", 0, 0, 1, 0, 20);
    drive(0, 0, 0, mk(0, 0));
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          failures++;
          $display("FAIL watchdog expired");
          $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
          $finish;
        end
      end
    join_none
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    step;
    t_reset;
    t_seq_closed;
    t_stream;
    t_cross;
    t_same_row;
    t_internal;
    t_idle_nonseq;
    t_write;
    t_hold;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule